// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time and space switch between two serial time-division multiplexed interfaces, called side A and side B. Each side has a group of duplex lines, each with one receive and one transmit pin, and one bit moves per line per clock. A side carries 128 eight-bit timeslots per frame. These slots can be spread over four lines of 32 slots, two lines of 64 slots, or one line of 128 slots. Slots are addressed by a linear number: line index times slots-per-line, plus the slot position on the line.

Every received slot is stored in a data memory with two banks. One bank fills during the current frame while the other is read out. The banks change roles at the end of each frame, so every switched channel has a delay of exactly one frame.

A control memory holds one entry per outgoing slot of each side, written through a single-cycle write port. Each entry names the source side, the source slot, and how the data is carried:
- a whole byte;
- an even-aligned pair of slots forming a 16-bit channel;
- a 4-bit field;
- a 2-bit field.

A frame-sync pulse aligns the bit and slot counters. A new line arrangement is applied only at a frame boundary.

Top module: `tsi_switch`

## Requirements
- R1: `mode_i` selects the line arrangement: 0 gives four lines of 32 slots (256 clocks per frame), 1 gives two lines of 64 slots, and 2 or 3 gives one line of 128 slots. The linear slot number is the line index times slots-per-line, plus the slot position on the line. Lines above the active count transmit constant 1 and their receive pins are ignored.
- R2: The first bit of a slot on a line is bit 7 (MSB) of the stored byte, and bit 0 comes last. A transmit bit leaves the block one clock after its bit position.
- R3: A slot transmitted in frame k carries data received in frame k-1. The two memory banks swap at the last bit of every frame.
- R4: A control write sets an entry in the cycle after `cfg_we_i`, and lookups use the new entry at once. The fields are:
  - address bit 7: destination side (0 = A, 1 = B);
  - address bits 6:0: destination linear slot;
  - data bit 14: valid;
  - data bit 13: source side;
  - data bits 12:6: source slot;
  - data bits 5:4: width code (0 byte, 1 nibble, 2 two-bit, 3 pair);
  - data bits 3:2: source field;
  - data bits 1:0: destination field.
- R5: Width code 0 copies the whole source byte from either side to the destination slot.
- R6: Width code 3, written at an even destination slot d, sends source slot s with bit 0 cleared to d, and the same slot with bit 0 set to d+1. Both halves come from the same received frame.
- R7: Width code 1 moves one nibble. Field bit 0 set selects bits 7:4 and clear selects bits 3:0, for both source and destination. The other nibble of the output is all ones.
- R8: Width code 2 moves bits 2k+1:2k of the source, where k is the source field, to bits 2j+1:2j of the output, where j is the destination field. All other output bits are 1.
- R9: An invalid entry (valid bit 0) transmits 8'hFF.
- R10: The cycle in which `fsync_i` is high is bit 7 of slot 0, whatever the counter phase was before.
- R11: A value of `mode_i` present during the last bit of a frame applies to the next frame. A change in the middle of a frame does not affect that frame.
- R12: After reset all transmit lines are 1, every control entry is invalid, and the arrangement is four lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| fsync_i | input | 1 | Frame start pulse |
| mode_i | input | 2 | Line arrangement select |
| cfg_we_i | input | 1 | Control entry write strobe |
| cfg_addr_i | input | 8 | Destination side and slot |
| cfg_wdata_i | input | 15 | Control entry contents |
| a_rx_i | input | 4 | Side A receive lines |
| a_tx_o | output | 4 | Side A transmit lines |
| b_rx_i | input | 4 | Side B receive lines |
| b_tx_o | output | 4 | Side B transmit lines |

## Verification
The hardest case is the frame after a change of line arrangement. That frame reads data stored under the old arrangement and maps it with the new one, and only a wrong boundary decision shows it. The bench first aligns the counters with a sync pulse at an arbitrary phase. It then runs several four-line frames and raises `mode_i` in the middle of one of them. Slot contents are predicted for the frame that is still four-line and for the following one-line frames, including the paired slots and the sub-byte fields.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   typedef enum logic [1:0] {
      FW_BYTE = 2'd0,
      FW_NIB  = 2'd1,
      FW_DUO  = 2'd2,
      FW_PAIR = 2'd3
   } fw_e;

   // Place a source field into an idle (all ones) output byte.
   function automatic logic [7:0] tsi_place(input logic [1:0] w, input logic [1:0] sf,
                                            input logic [1:0] df, input logic [7:0] src);
      logic [7:0] r;
      logic [3:0] nib;
      logic [1:0] duo;
      r   = '1;
      nib = sf[0] ? src[7:4] : src[3:0];
      duo = src[{sf, 1'b0} +: 2];
      case (fw_e'(w))
         FW_NIB:  if (df[0]) r[7:4] = nib; else r[3:0] = nib;
         FW_DUO:  r[{df, 1'b0} +: 2] = duo;
         default: r = src;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr #(
   parameter  int LINES    = 4,
   parameter  int SLOTS    = 128,
   localparam int POS_W    = $clog2(SLOTS * 8),
   localparam int MODE_MAX = $clog2(LINES),
   localparam int MSEL_W   = (MODE_MAX < 2) ? 1 : $clog2(MODE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic [MSEL_W-1:0] mode_i,
   output logic [POS_W-1:0]  pos_o,
   output logic [MSEL_W-1:0] msel_o,
   output logic              last_o,
   output logic              wbank_o
);
   logic [POS_W-1:0]  cnt_q;
   logic [MSEL_W-1:0] msel_q, msel_nx;
   logic              wbank_q;
   logic [POS_W:0]    fbits;

   assign pos_o   = fsync_i ? '0 : cnt_q;
   assign fbits   = (POS_W + 1)'((SLOTS / LINES) * 8) << msel_q;
   assign last_o  = ({1'b0, pos_o} == fbits - 1'b1);
   assign msel_nx = (int'(mode_i) > MODE_MAX) ? MSEL_W'(MODE_MAX) : mode_i;
   assign msel_o  = msel_q;
   assign wbank_o = wbank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         msel_q  <= '0;
         wbank_q <= 1'b0;
      end else begin
         cnt_q <= last_o ? '0 : pos_o + 1'b1;
         if (last_o) begin
            msel_q  <= msel_nx;
            wbank_q <= ~wbank_q;
         end
      end
   end

   // R10
   fsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_i |=> (cnt_q == POS_W'(1)));
   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !last_o |=> $stable(msel_q));
   // R3
   bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (wbank_q != $past(wbank_q)));
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
   parameter  int LINES    = 4,
   parameter  int SLOTS    = 128,
   localparam int POS_W    = $clog2(SLOTS * 8),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int MODE_MAX = $clog2(LINES),
   localparam int MSEL_W   = (MODE_MAX < 2) ? 1 : $clog2(MODE_MAX + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LINES-1:0]             rx_i,
   input  logic [POS_W-1:0]             pos_i,
   input  logic [MSEL_W-1:0]            msel_i,
   input  logic                         wbank_i,
   output logic [1:0][SLOTS-1:0][7:0]   mem_o
);
   logic [6:0] sh_q [LINES];
   int         lines_act, spp;

   always_comb begin
      lines_act = LINES >> msel_i;
      spp       = (SLOTS / LINES) << msel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_o <= '1;
         for (int l = 0; l < LINES; l++) sh_q[l] <= '0;
      end else begin
         for (int l = 0; l < LINES; l++) begin
            if (l < lines_act) begin
               sh_q[l] <= {sh_q[l][5:0], rx_i[l]};
               if (pos_i[2:0] == 3'd7)
                  mem_o[wbank_i][SLOT_W'(l * spp + int'(pos_i[POS_W-1:3]))] <= {sh_q[l], rx_i[l]};
            end
         end
      end
   end
endmodule

// File: rtl/tsi_compose.sv
module tsi_compose import tsi_pkg::*; #(
   parameter  int LINES    = 4,
   parameter  int SLOTS    = 128,
   parameter  int IFACE    = 0,
   localparam int POS_W    = $clog2(SLOTS * 8),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int EW       = SLOT_W + 8,
   localparam int MODE_MAX = $clog2(LINES),
   localparam int MSEL_W   = (MODE_MAX < 2) ? 1 : $clog2(MODE_MAX + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [POS_W-1:0]                  pos_i,
   input  logic [MSEL_W-1:0]                 msel_i,
   input  logic                              rbank_i,
   input  logic                              cfg_we_i,
   input  logic [SLOT_W:0]                   cfg_addr_i,
   input  logic [EW-1:0]                     cfg_wdata_i,
   input  logic [1:0][1:0][SLOTS-1:0][7:0]   dmem_i,
   output logic [LINES-1:0]                  tx_o
);
   localparam int VB = EW - 1;
   localparam int SB = EW - 2;

   logic [EW-1:0] cm [SLOTS];
   int            lines_act, spp;

   always_comb begin
      lines_act = LINES >> msel_i;
      spp       = (SLOTS / LINES) << msel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) cm[i] <= '0;
      end else if (cfg_we_i && (int'(cfg_addr_i[SLOT_W]) == IFACE)) begin
         cm[cfg_addr_i[SLOT_W-1:0]] <= cfg_wdata_i;
      end
   end

   for (genvar gl = 0; gl < LINES; gl++) begin : g_line
      logic [SLOT_W-1:0] dst;
      logic [EW-1:0]     ev, own;
      logic [7:0]        frm;
      logic              tx_r;

      assign dst = SLOT_W'(gl * spp + int'(pos_i[POS_W-1:3]));
      assign ev  = cm[{dst[SLOT_W-1:1], 1'b0}];
      assign own = cm[dst];

      always_comb begin
         if (ev[VB] && (fw_e'(ev[5:4]) == FW_PAIR))
            frm = dmem_i[ev[SB]][rbank_i][{ev[SLOT_W+5:7], dst[0]}];
         else if (own[VB])
            frm = tsi_place(own[5:4], own[3:2], own[1:0],
                            dmem_i[own[SB]][rbank_i][own[SLOT_W+5:6]]);
         else
            frm = 8'hFF;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tx_r <= 1'b1;
         else        tx_r <= (gl < lines_act) ? frm[~pos_i[2:0]] : 1'b1;
      end
      assign tx_o[gl] = tx_r;

      // R1
      idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gl >= lines_act) |=> tx_r);
   end

   // R4
   cm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && (int'(cfg_addr_i[SLOT_W]) == IFACE))
         |=> (cm[$past(cfg_addr_i[SLOT_W-1:0])] == $past(cfg_wdata_i)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
   parameter  int LINES    = 4,
   parameter  int SLOTS    = 128,
   localparam int POS_W    = $clog2(SLOTS * 8),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int EW       = SLOT_W + 8,
   localparam int MODE_MAX = $clog2(LINES),
   localparam int MSEL_W   = (MODE_MAX < 2) ? 1 : $clog2(MODE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic [MSEL_W-1:0] mode_i,
   input  logic              cfg_we_i,
   input  logic [SLOT_W:0]   cfg_addr_i,
   input  logic [EW-1:0]     cfg_wdata_i,
   input  logic [LINES-1:0]  a_rx_i,
   output logic [LINES-1:0]  a_tx_o,
   input  logic [LINES-1:0]  b_rx_i,
   output logic [LINES-1:0]  b_tx_o
);
   initial begin
      static_cfg_chk: assert ((SLOTS == (1 << SLOT_W)) && (LINES == (1 << MODE_MAX))
                              && (SLOTS >= 2 * LINES) && (SLOT_W >= 2))
         else $fatal(1, "tsi_switch: slot and line counts must be powers of two");
   end

   logic [POS_W-1:0]                 pos;
   logic [MSEL_W-1:0]                msel;
   logic                             last, wbank;
   logic [1:0][LINES-1:0]            rx_all, tx_all;
   logic [1:0][1:0][SLOTS-1:0][7:0]  dmem;

   assign rx_all = {b_rx_i, a_rx_i};
   assign a_tx_o = tx_all[0];
   assign b_tx_o = tx_all[1];

   tsi_frame_ctr #(.LINES(LINES), .SLOTS(SLOTS)) u_ctr (
      .clk, .rst_n, .fsync_i, .mode_i,
      .pos_o(pos), .msel_o(msel), .last_o(last), .wbank_o(wbank)
   );

   for (genvar gi = 0; gi < 2; gi++) begin : g_side
      tsi_rx_store #(.LINES(LINES), .SLOTS(SLOTS)) u_store (
         .clk, .rst_n, .rx_i(rx_all[gi]), .pos_i(pos), .msel_i(msel),
         .wbank_i(wbank), .mem_o(dmem[gi])
      );
      tsi_compose #(.LINES(LINES), .SLOTS(SLOTS), .IFACE(gi)) u_comp (
         .clk, .rst_n, .pos_i(pos), .msel_i(msel), .rbank_i(~wbank),
         .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .dmem_i(dmem), .tx_o(tx_all[gi])
      );
   end

   // R3
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (pos == '0));
endmodule

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        fsync = 1'b0, cfg_we = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [7:0]  cfg_addr = '0;
   logic [14:0] cfg_wdata = '0;
   logic [3:0]  a_rx = '0, b_rx = '0, a_tx, b_tx;

   tsi_switch dut_i (
      .clk, .rst_n, .fsync_i(fsync), .mode_i(mode), .cfg_we_i(cfg_we),
      .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
      .a_rx_i(a_rx), .a_tx_o(a_tx), .b_rx_i(b_rx), .b_tx_o(b_tx)
   );

   typedef struct { int frame; int iface; int line; int slot; logic [7:0] exp; string tag; } item_t;
   typedef struct { int iface; int line; int slot; string tag; } spec_t;

   item_t       sb_q[$];
   logic [14:0] mir [2][128];
   logic [7:0]  cap [2][4];
   int          n_chk = 0, n_fail = 0;
   int          pv_valid = 0, pv_p = 0, pv_f = 0;

   spec_t spec4[10] = '{'{0,0,3,"R5"}, '{0,1,8,"R3"}, '{0,0,10,"R6"}, '{0,0,11,"R6"},
                        '{0,3,4,"R7"}, '{0,3,5,"R8"}, '{0,1,18,"R9"}, '{1,3,31,"R2"},
                        '{1,2,0,"R4"}, '{1,0,0,"R10"}};
   spec_t spec1[7]  = '{'{0,0,3,"R1"}, '{0,0,10,"R6"}, '{0,0,11,"R6"}, '{0,0,100,"R11"},
                        '{1,0,127,"R2"}, '{0,2,7,"R1"}, '{1,1,100,"R1"}};

   function automatic logic [7:0] pat(int f, int i, int lin);
      return 8'(f * 53 + i * 97 + lin * 29 + 11);
   endfunction

   // Expected output byte of destination slot lin on side i in frame f.
   function automatic logic [7:0] model(int i, int lin, int f);
      logic [14:0] e, ev;
      logic [7:0]  s, r;
      logic [3:0]  nib;
      ev = mir[i][lin & ~1];
      if (ev[14] && ev[5:4] == 2'd3)
         return pat(f - 1, int'(ev[13]), (int'(ev[12:6]) & ~1) | (lin & 1));
      e = mir[i][lin];
      if (!e[14]) return 8'hFF;
      s = pat(f - 1, int'(e[13]), int'(e[12:6]));
      r = 8'hFF;
      case (e[5:4])
         2'd1: begin
            nib = e[2] ? s[7:4] : s[3:0];
            if (e[0]) r[7:4] = nib; else r[3:0] = nib;
         end
         2'd2: r[2 * int'(e[1:0]) +: 2] = s[2 * int'(e[3:2]) +: 2];
         default: r = s;
      endcase
      return r;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic cfg(int i, int lin, int v, int sif, int ssl, int w, int sf, int df);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = {1'(i), 7'(lin)};
      cfg_wdata = {1'(v), 1'(sif), 7'(ssl), 2'(w), 2'(sf), 2'(df)};
      mir[i][lin] = cfg_wdata;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Driver side of the scoreboard: queue the expected bytes of frame f.
   task automatic push_frame(int f, int md);
      int spp, lines;
      spp   = 32 << md;
      lines = 4 >> md;
      for (int s = 0; s < spp; s++) begin
         if (md == 0) begin
            foreach (spec4[k]) if (spec4[k].slot == s)
               sb_q.push_back('{f, spec4[k].iface, spec4[k].line, s,
                                model(spec4[k].iface, spec4[k].line * spp + s, f), spec4[k].tag});
         end else begin
            foreach (spec1[k]) if (spec1[k].slot == s)
               sb_q.push_back('{f, spec1[k].iface, spec1[k].line, s,
                                (spec1[k].line >= lines) ? 8'hFF
                                   : model(spec1[k].iface, spec1[k].line * spp + s, f),
                                spec1[k].tag});
         end
      end
   endtask

   // Monitor side: deserialise the transmit lines and compare at slot ends.
   task automatic monitor_step();
      item_t it;
      if (pv_valid == 0) return;
      for (int l = 0; l < 4; l++) begin
         cap[0][l] = {cap[0][l][6:0], a_tx[l]};
         cap[1][l] = {cap[1][l][6:0], b_tx[l]};
      end
      if (pv_p % 8 == 7) begin
         while (sb_q.size() > 0 && sb_q[0].frame == pv_f && sb_q[0].slot == pv_p / 8) begin
            it = sb_q.pop_front();
            check(cap[it.iface][it.line] == it.exp, it.tag,
                  $sformatf("frame %0d side %0d line %0d slot %0d", it.frame, it.iface, it.line, it.slot),
                  cap[it.iface][it.line], it.exp);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int md, spp, lines, fl;
      for (int i = 0; i < 2; i++) for (int j = 0; j < 128; j++) mir[i][j] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset leaves every transmit line idle
      check({a_tx, b_tx} == 8'hFF, "R12", "transmit lines after reset", {a_tx, b_tx}, 8'hFF);

      cfg(0, 3,   1, 1, 70,  0, 0, 0);  // R5 byte from the other side
      cfg(0, 40,  1, 0, 5,   0, 0, 0);  // R3 byte from the same side
      cfg(0, 10,  1, 1, 20,  3, 0, 0);  // R6 pair into slots 10 and 11
      cfg(0, 100, 1, 0, 9,   1, 1, 0);  // R7 high nibble to low nibble
      cfg(0, 101, 1, 1, 33,  2, 0, 3);  // R8 bits 1:0 to bits 7:6
      cfg(1, 127, 1, 0, 0,   0, 0, 0);  // R2 last slot of the frame
      cfg(1, 64,  1, 0, 7,   0, 0, 0);
      cfg(1, 64,  0, 0, 7,   0, 0, 0);  // R4 entry rewritten as invalid
      cfg(1, 0,   1, 0, 127, 0, 0, 0);  // R10 first slot after sync
      repeat (37) @(negedge clk);       // counters drift to an arbitrary phase

      md = 0;
      for (int f = 0; f < 7; f++) begin
         spp   = 32 << md;
         lines = 4 >> md;
         fl    = spp * 8;
         if (f >= 1) push_frame(f, md);
         for (int p = 0; p < fl; p++) begin
            @(negedge clk);
            monitor_step();
            fsync = (p == 0);
            for (int l = 0; l < 4; l++) begin
               a_rx[l] = (l < lines) ? pat(f, 0, l * spp + p / 8)[7 - p % 8] : 1'b0;
               b_rx[l] = (l < lines) ? pat(f, 1, l * spp + p / 8)[7 - p % 8] : 1'b0;
            end
            if (f == 4 && p == 100) mode = 2'd2;  // R11 change in mid-frame
            pv_valid = 1;
            pv_p     = p;
            pv_f     = f;
         end
         md = (mode > 2'd2) ? 2 : int'(mode);
      end
      @(negedge clk);
      monitor_step();
      check(sb_q.size() == 0, "R3", "items left unmatched", 8'(sb_q.size()), 8'h00);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule